// File: doc/BRIEF.md
# SMBus Bus Timeout Detector

This block watches the already-synchronized SCL and SDA levels of a two-wire serial interface and raises a sticky timeout error when the bus misbehaves. It has two independent detectors. The first, the bus-hold detector, runs in one of two modes. In low mode it measures one unbroken period of SCL low. In idle mode it measures one unbroken period with both SCL and SDA high. The second, the extension detector, adds up every cycle in which the local interface is stretching the clock, across the whole of one transfer. The transfer is delimited by start and stop strobes from the protocol engine.

Both limits come from 12-bit threshold fields. In low mode and for the extension detector, the limit is (T+1) units of 2048 kernel clocks. In idle mode, the bus-hold detector uses units of 4 kernel clocks. A threshold and its mode bit are frozen while their detector is enabled. Writes to them at that time are dropped. The enable bits themselves can always be written. The current configuration can be read back on output ports. The error flag stays set until a clear pulse arrives.

Top module: `smbus_timeout_det`

## Requirements
- R1: After reset, both enables, the idle-mode bit, both thresholds and `timeout_o` are all 0.
- R2: In low mode (`cfg_a_idle_o`=0) with the bus-hold detector enabled, `timeout_o` reads 1 in the cycle after SCL has been sampled low for (A+1)·2048 consecutive cycles, and not earlier.
- R3: In low mode, SCL sampled high restarts the low measurement from zero.
- R4: In idle mode (`cfg_a_idle_o`=1), `timeout_o` reads 1 in the cycle after SCL and SDA have both been sampled high for (A+1)·4 consecutive cycles. Either line sampled low restarts the measurement.
- R5: In idle mode, a long SCL-low period does not raise the error.
- R6: With the extension detector enabled, cycles with `stretch_i`=1 accumulate across separate stretch periods. `timeout_o` reads 1 in the cycle after the accumulated total reaches (B+1)·2048. Cycles with `stretch_i`=0 neither add nor reset.
- R7: A `start_i` or `stop_i` pulse resets the accumulated extension total to zero.
- R8: A bus-hold write (`wr_a_i`) always loads the enable. It loads the idle bit and threshold A only if the bus-hold detector was disabled before the write. An extension write (`wr_b_i`) always loads its enable, and loads threshold B only if the extension detector was disabled before the write.
- R9: `timeout_o` stays set until `clr_i`=1 clears it. A detector firing in the same cycle as `clr_i` leaves `timeout_o` set.
- R10: Each detector reports once per unbroken condition. After a clear, a condition that simply continues does not set `timeout_o` again.
- R11: A disabled detector never sets `timeout_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Kernel clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA level |
| stretch_i | input | 1 | Local interface is holding SCL low |
| start_i | input | 1 | Start-condition strobe from protocol engine |
| stop_i | input | 1 | Stop-condition strobe from protocol engine |
| wr_a_i | input | 1 | Write strobe for bus-hold configuration |
| wdat_a_en_i | input | 1 | Bus-hold enable write data |
| wdat_a_idle_i | input | 1 | Idle-mode bit write data (1 = idle mode) |
| wdat_a_thr_i | input | 12 | Threshold A write data |
| wr_b_i | input | 1 | Write strobe for extension configuration |
| wdat_b_en_i | input | 1 | Extension enable write data |
| wdat_b_thr_i | input | 12 | Threshold B write data |
| clr_i | input | 1 | Clears the timeout flag |
| timeout_o | output | 1 | Sticky timeout error |
| cfg_a_en_o | output | 1 | Bus-hold enable readback |
| cfg_a_idle_o | output | 1 | Idle-mode readback |
| cfg_a_thr_o | output | 12 | Threshold A readback |
| cfg_b_en_o | output | 1 | Extension enable readback |
| cfg_b_thr_o | output | 12 | Threshold B readback |

## Verification
The bench samples the flag one cycle before and exactly at the expected firing cycle for thresholds 0 and 1 in low mode and for the extension detector, and sweeps thresholds 0 to 7 in idle mode. This exposes a design that counts one unit too few or too many, or that uses the wrong prescaler for a mode. A one-cycle SCL-high blip, and one-cycle low blips on either line in idle mode, catch a design that fails to restart its count and so fires early. Extension stretching is split into several pieces with gaps between them. A design that resets on each gap would never fire, and one that counts gap cycles would fire early; a start/stop strobe in mid-transfer must push the firing point back. Writes made while a detector is enabled, a clear that coincides with a firing, and a condition that continues after a clear check the lock rules, the set-over-clear priority and the single report per episode.

// File: rtl/smbto_pkg.sv
package smbto_pkg;

    localparam int unsigned THR_W = 12;

    typedef enum logic {
        HOLD_LOW  = 1'b0,
        HOLD_IDLE = 1'b1
    } hold_mode_e;

    typedef struct packed {
        logic              en;
        hold_mode_e        mode;
        logic [THR_W-1:0]  thr;
    } hold_cfg_t;

    typedef struct packed {
        logic              en;
        logic [THR_W-1:0]  thr;
    } ext_cfg_t;

endpackage

// File: rtl/smbto_cfg.sv
module smbto_cfg
    import smbto_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_a_i,
    input  logic             en_a_i,
    input  logic             idle_a_i,
    input  logic [THR_W-1:0] thr_a_i,
    input  logic             wr_b_i,
    input  logic             en_b_i,
    input  logic [THR_W-1:0] thr_b_i,
    output hold_cfg_t        hold_o,
    output ext_cfg_t         ext_o
);

    typedef struct packed {
        hold_cfg_t hold;
        ext_cfg_t  ext;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_a_i) begin
            st_d.hold.en = en_a_i;
            if (!st_q.hold.en) begin
                st_d.hold.mode = hold_mode_e'(idle_a_i);
                st_d.hold.thr  = thr_a_i;
            end
        end
        if (wr_b_i) begin
            st_d.ext.en = en_b_i;
            if (!st_q.ext.en) begin
                st_d.ext.thr = thr_b_i;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign hold_o = st_q.hold;
    assign ext_o  = st_q.ext;

    assert_lock_a_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.hold.en |=> ($stable(st_q.hold.thr) && $stable(st_q.hold.mode)));

    assert_lock_b_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.ext.en |=> $stable(st_q.ext.thr));

endmodule

// File: rtl/smbto_meas.sv
module smbto_meas #(
    parameter int unsigned PRE_W = 11,
    parameter int unsigned CNT_W = 12
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             count_i,
    input  logic             clear_i,
    input  logic [PRE_W-1:0] pre_last_i,
    input  logic [CNT_W-1:0] thr_i,
    output logic             hit_o
);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [CNT_W-1:0] units;
        logic             fired;
    } meas_state_t;

    meas_state_t st_d, st_q;
    logic tick;

    always_comb begin
        st_d  = st_q;
        tick  = count_i && (st_q.pre == pre_last_i);
        hit_o = tick && (st_q.units == thr_i) && !st_q.fired && !clear_i;
        if (clear_i) begin
            st_d = '0;
        end else if (count_i) begin
            st_d.pre = tick ? '0 : st_q.pre + 1'b1;
            if (tick && (st_q.units != thr_i)) st_d.units = st_q.units + 1'b1;
            if (hit_o) st_d.fired = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assert_single_hit_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hit_o |=> !hit_o);

    assert_units_bounded_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.units <= thr_i);

endmodule

// File: rtl/smbus_timeout_det.sv
module smbus_timeout_det
    import smbto_pkg::*;
#(
    parameter int unsigned LONG_SHIFT = 11,
    parameter int unsigned IDLE_SHIFT = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic             stretch_i,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             wr_a_i,
    input  logic             wdat_a_en_i,
    input  logic             wdat_a_idle_i,
    input  logic [THR_W-1:0] wdat_a_thr_i,
    input  logic             wr_b_i,
    input  logic             wdat_b_en_i,
    input  logic [THR_W-1:0] wdat_b_thr_i,
    input  logic             clr_i,
    output logic             timeout_o,
    output logic             cfg_a_en_o,
    output logic             cfg_a_idle_o,
    output logic [THR_W-1:0] cfg_a_thr_o,
    output logic             cfg_b_en_o,
    output logic [THR_W-1:0] cfg_b_thr_o
);

    localparam int unsigned PRE_W    = LONG_SHIFT;
    localparam int unsigned LONG_DIV = 1 << LONG_SHIFT;
    localparam int unsigned IDLE_DIV = 1 << IDLE_SHIFT;
    localparam logic [PRE_W-1:0] LONG_LAST = PRE_W'(LONG_DIV - 1);
    localparam logic [PRE_W-1:0] IDLE_LAST = PRE_W'(IDLE_DIV - 1);

    hold_cfg_t hold_cfg;
    ext_cfg_t  ext_cfg;

    smbto_cfg u_cfg (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_a_i   (wr_a_i),
        .en_a_i   (wdat_a_en_i),
        .idle_a_i (wdat_a_idle_i),
        .thr_a_i  (wdat_a_thr_i),
        .wr_b_i   (wr_b_i),
        .en_b_i   (wdat_b_en_i),
        .thr_b_i  (wdat_b_thr_i),
        .hold_o   (hold_cfg),
        .ext_o    (ext_cfg)
    );

    logic hold_cond, hold_count, hold_clear, hold_hit;
    logic ext_count, ext_clear, ext_hit;
    logic [PRE_W-1:0] hold_last;

    always_comb begin
        hold_cond  = (hold_cfg.mode == HOLD_IDLE) ? (scl_i && sda_i) : !scl_i;
        hold_count = hold_cfg.en && hold_cond;
        hold_clear = !hold_count;
        hold_last  = (hold_cfg.mode == HOLD_IDLE) ? IDLE_LAST : LONG_LAST;
        ext_count  = ext_cfg.en && stretch_i;
        ext_clear  = !ext_cfg.en || start_i || stop_i;
    end

    smbto_meas #(.PRE_W(PRE_W), .CNT_W(THR_W)) u_hold (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .count_i    (hold_count),
        .clear_i    (hold_clear),
        .pre_last_i (hold_last),
        .thr_i      (hold_cfg.thr),
        .hit_o      (hold_hit)
    );

    smbto_meas #(.PRE_W(PRE_W), .CNT_W(THR_W)) u_ext (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .count_i    (ext_count),
        .clear_i    (ext_clear),
        .pre_last_i (LONG_LAST),
        .thr_i      (ext_cfg.thr),
        .hit_o      (ext_hit)
    );

    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (hold_hit || ext_hit) flag_d = 1'b1;
        else if (clr_i)          flag_d = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) flag_q <= 1'b0;
        else         flag_q <= flag_d;
    end

    assign timeout_o    = flag_q;
    assign cfg_a_en_o   = hold_cfg.en;
    assign cfg_a_idle_o = (hold_cfg.mode == HOLD_IDLE);
    assign cfg_a_thr_o  = hold_cfg.thr;
    assign cfg_b_en_o   = ext_cfg.en;
    assign cfg_b_thr_o  = ext_cfg.thr;

    assert_flag_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_q && !clr_i) |=> flag_q);

    assert_hit_sets_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hold_hit || ext_hit) |=> flag_q);

    assert_disabled_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!hold_cfg.en |-> !hold_hit) and (!ext_cfg.en |-> !ext_hit));

    assert_idle_needs_high_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hold_hit && hold_cfg.mode == HOLD_IDLE) |-> (scl_i && sda_i));

endmodule

// File: tb/smbus_timeout_det_tb.sv
module smbus_timeout_det_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1, sda = 1'b0, stretch = 1'b0, start_ev = 1'b0, stop_ev = 1'b0;
    logic        wr_a = 1'b0, wa_en = 1'b0, wa_idle = 1'b0;
    logic [11:0] wa_thr = '0;
    logic        wr_b = 1'b0, wb_en = 1'b0;
    logic [11:0] wb_thr = '0;
    logic        clr = 1'b0;
    logic        timeout, a_en, a_idle, b_en;
    logic [11:0] a_thr, b_thr;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    smbus_timeout_det u_dut (
        .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda), .stretch_i(stretch),
        .start_i(start_ev), .stop_i(stop_ev),
        .wr_a_i(wr_a), .wdat_a_en_i(wa_en), .wdat_a_idle_i(wa_idle), .wdat_a_thr_i(wa_thr),
        .wr_b_i(wr_b), .wdat_b_en_i(wb_en), .wdat_b_thr_i(wb_thr),
        .clr_i(clr), .timeout_o(timeout),
        .cfg_a_en_o(a_en), .cfg_a_idle_o(a_idle), .cfg_a_thr_o(a_thr),
        .cfg_b_en_o(b_en), .cfg_b_thr_o(b_thr)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cfg_a(input bit en, input bit idle, input int thr);
        @(negedge clk);
        wr_a = 1'b1; wa_en = en; wa_idle = idle; wa_thr = 12'(thr);
        @(negedge clk);
        wr_a = 1'b0;
    endtask

    task automatic cfg_b(input bit en, input int thr);
        @(negedge clk);
        wr_b = 1'b1; wb_en = en; wb_thr = 12'(thr);
        @(negedge clk);
        wr_b = 1'b0;
    endtask

    task automatic clear_flag();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
    endtask

    // condition was applied at the current negedge; flag must rise exactly after n counted edges
    task automatic run_hold(input string req, input int n);
        repeat (n - 1) @(posedge clk);
        @(negedge clk);
        chk(req, timeout, 0);
        @(posedge clk);
        @(negedge clk);
        chk(req, timeout, 1);
    endtask

    task automatic idle_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : stim
        int rem;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 timeout", timeout, 0);
        chk("R1 a_en", a_en, 0);
        chk("R1 a_idle", a_idle, 0);
        chk("R1 a_thr", a_thr, 0);
        chk("R1 b_en", b_en, 0);
        chk("R1 b_thr", b_thr, 0);

        // R11 disabled detectors stay quiet
        scl = 1'b0; stretch = 1'b1;
        idle_cycles(5000);
        chk("R11 disabled", timeout, 0);
        scl = 1'b1; stretch = 1'b0;

        // R2 low mode, thresholds 0 and 1
        for (int a = 0; a < 2; a++) begin
            cfg_a(1, 0, a);
            scl = 1'b0;
            run_hold("R2", (a + 1) * 2048);
            scl = 1'b1;
            cfg_a(0, 0, 0);
            clear_flag();
            chk("R9 cleared", timeout, 0);
        end

        // R3 SCL high blip restarts the low count
        cfg_a(1, 0, 0);
        scl = 1'b0;
        idle_cycles(2000);
        scl = 1'b1;
        idle_cycles(1);
        chk("R3 no early fire", timeout, 0);
        scl = 1'b0;
        run_hold("R3", 2048);

        // R9 clear, R10 continuing condition does not re-report
        clear_flag();
        chk("R9 clear", timeout, 0);
        idle_cycles(3000);
        chk("R10 single report", timeout, 0);
        scl = 1'b1;
        idle_cycles(1);
        // R9 firing and clearing in the same cycle
        scl = 1'b0;
        repeat (2047) @(posedge clk);
        @(negedge clk);
        chk("R9 pre", timeout, 0);
        clr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        clr = 1'b0;
        chk("R9 set wins over clear", timeout, 1);
        scl = 1'b1;
        cfg_a(0, 0, 0);
        clear_flag();

        // R4 idle mode sweep of thresholds 0..7
        for (int a = 0; a < 8; a++) begin
            cfg_a(1, 1, a);
            sda = 1'b1;
            run_hold("R4 sweep", (a + 1) * 4);
            sda = 1'b0;
            cfg_a(0, 1, a);
            clear_flag();
        end
        // R4 restart by SCL low, then by SDA low
        cfg_a(1, 1, 2);
        sda = 1'b1;
        idle_cycles(8);
        scl = 1'b0;
        idle_cycles(1);
        scl = 1'b1;
        run_hold("R4 scl restart", 12);
        cfg_a(0, 1, 2);
        clear_flag();
        cfg_a(1, 1, 2);
        idle_cycles(10);
        sda = 1'b0;
        idle_cycles(1);
        chk("R4 no early fire", timeout, 0);
        sda = 1'b1;
        run_hold("R4 sda restart", 12);
        sda = 1'b0;
        cfg_a(0, 1, 2);
        clear_flag();

        // R5 idle mode ignores long SCL low
        cfg_a(1, 1, 0);
        scl = 1'b0;
        idle_cycles(5000);
        chk("R5 low ignored in idle mode", timeout, 0);
        scl = 1'b1;
        cfg_a(0, 0, 0);

        // R8 write locks
        cfg_a(1, 0, 5);
        chk("R8 a_thr load", a_thr, 5);
        chk("R8 a_en load", a_en, 1);
        cfg_a(1, 1, 9);
        chk("R8 a_thr locked", a_thr, 5);
        chk("R8 a_idle locked", a_idle, 0);
        cfg_a(0, 1, 9);
        chk("R8 a_en always", a_en, 0);
        chk("R8 a_thr still locked", a_thr, 5);
        cfg_a(0, 1, 9);
        chk("R8 a_thr unlocked", a_thr, 9);
        chk("R8 a_idle unlocked", a_idle, 1);
        cfg_b(1, 7);
        chk("R8 b_thr load", b_thr, 7);
        cfg_b(1, 3);
        chk("R8 b_thr locked", b_thr, 7);
        cfg_b(0, 3);
        chk("R8 b_en always", b_en, 0);
        chk("R8 b_thr still locked", b_thr, 7);
        chk("R11 quiet", timeout, 0);

        // R6 cumulative stretch across separate pieces
        for (int b = 0; b < 2; b++) begin
            cfg_b(1, b);
            rem = (b + 1) * 2048;
            while (rem > 500) begin
                stretch = 1'b1;
                idle_cycles(500);
                stretch = 1'b0;
                idle_cycles(100);
                chk("R6 partial", timeout, 0);
                rem -= 500;
            end
            stretch = 1'b1;
            run_hold("R6", rem);
            stretch = 1'b0;
            cfg_b(0, 0);
            clear_flag();
        end

        // R7 start and stop strobes reset the total
        cfg_b(1, 0);
        stretch = 1'b1;
        idle_cycles(1500);
        stretch = 1'b0; stop_ev = 1'b1;
        idle_cycles(1);
        stop_ev = 1'b0;
        stretch = 1'b1;
        idle_cycles(1500);
        chk("R7 stop resets", timeout, 0);
        stretch = 1'b0; start_ev = 1'b1;
        idle_cycles(1);
        start_ev = 1'b0;
        stretch = 1'b1;
        run_hold("R7 after start", 2048);
        stretch = 1'b0;
        cfg_b(0, 0);
        clear_flag();
        chk("R9 final clear", timeout, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule